// File: doc/BRIEF.md
# Mailbox Request Sequencer

This block is the requesting side of an eight-word shared mailbox window. A single start command makes it take the window, post a message and collect the answer over a simple register read/write master port. First it reads the control word (word 7) until the ownership flag in bit 31 is clear, so that the window belongs to the requester. It then writes the message and polls the control word again until the other side hands ownership back. Finally it classifies the response header.

A full message is seven payload words followed by the control header. The header goes last because writing it passes ownership to the responder. A short command (type 2) writes only the header. Every polling phase is bounded: at most `POLL_LIMIT` reads, separated by `POLL_GAP` idle cycles. The outcome is reported as one done pulse carrying a two-bit result code. When the requester asked for a reset, a window that reads all ones counts as a finished exchange, because a device under reset returns all ones.

Top module: `mbx_req_seq`

## Requirements
- R1: A start is accepted only while `busy_o` is low. `busy_o` then stays high until the single-cycle `done_o` pulse, and exactly one pulse follows each accepted start. A start while busy is ignored, as are changes to the command inputs while busy. Result codes on `result_o` during `done_o` are: 0 success, 1 timeout, 2 protocol error, 3 operation failure.
- R2: After an accepted start, the block reads word address 7 (and no other address) until a read returns bit 31 = 0. Only then does it issue any write.
- R3: Consecutive poll reads in one phase are separated by exactly `POLL_GAP` cycles with the request low. If `POLL_LIMIT` reads in one phase all find the window not owned, the block ends with result 1 and makes no further bus access.
- R4: For any type other than 2, the message is written to addresses 0 to 6 in ascending order with payload word k = `payload_i[32k+31:32k]`. The header write to address 7 comes last.
- R5: For type 2 the only write is the header to address 7.
- R6: The header word holds type in bits 2:0, version in bits 5:3 and the reset flag in bit 24. All other bits are 0, which means direction bit 7 = 0 and status bits 15:8 = 0.
- R7: After the header write, word 7 is polled until bit 31 = 0. With the reset flag set, a read of 0xFFFFFFFF also ends polling and gives result 0 without any field checks. Before the message is written, 0xFFFFFFFF always counts as not owned.
- R8: The response is a protocol error (result 2) when bits 2:0 differ from the request type, when bits 5:3 exceed the request version, or when bit 7 is 0. A lower or equal version is accepted.
- R9: A response that passes R8 but has a nonzero status byte (bits 15:8) gives result 3. Otherwise the result is 0. Protocol errors take priority over the status byte.
- R10: `bus_req_o` stays high with stable `bus_we_o`, `bus_addr_o` and `bus_wdata_o` until the cycle in which `bus_ack_i` is high. That cycle completes the access, and for reads `bus_rdata_i` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start command pulse |
| msg_type_i | input | 3 | Request message type |
| msg_ver_i | input | 3 | Request message version |
| reset_req_i | input | 1 | Reset-request flag for the header |
| payload_i | input | 32*(NUM_WORDS-1) | Payload words, word 0 in the low bits |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code, valid with done_o |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | $clog2(NUM_WORDS) | Word address in the window |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access completion |
| bus_rdata_i | input | 32 | Read data, valid with bus_ack_i |

## Verification
The in-design assertions watch several rules on every cycle. They hold the request steady until its acknowledge, keep writes in ascending address order, keep header writes free of direction and status bits, and make short commands go straight to the control word. They also keep done pulses to one cycle, keep the bus quiet when idle and keep the poll attempt counter inside its limit. Other properties need complete scenarios, which only the bench provides. These are the response classification (version ordering, type and direction mismatch, status priority), the reset all-ones shortcut compared with its rejection before the message is written, both timeout phases, the exact idle gap between polls, and ignoring a start while busy.

// File: rtl/mbx_seq_pkg.sv
// Package: shared types and header field layout for the mailbox request
// sequencer. The field positions are fixed by the responder, which decodes them.
package mbx_seq_pkg;

    localparam int HDR_W        = 32;
    localparam int F_TYPE_LSB   = 0;
    localparam int F_VER_LSB    = 3;
    localparam int F_DIR_BIT    = 7;
    localparam int F_STAT_LSB   = 8;
    localparam int F_RST_BIT    = 24;
    localparam int F_OWN_BIT    = 31;
    localparam logic [2:0] TYPE_SHORT = 3'd2;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_PROTO   = 2'd2,
        RES_OPFAIL  = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_RD,
        ST_PRE_GAP,
        ST_WRITE,
        ST_POST_RD,
        ST_POST_GAP,
        ST_DONE
    } st_e;

    // Compose a request header: direction and status stay zero.
    function automatic logic [HDR_W-1:0] mk_header(input logic [2:0] t,
                                                   input logic [2:0] v,
                                                   input logic       r);
        logic [HDR_W-1:0] h;
        h = '0;
        h[F_TYPE_LSB +: 3] = t;
        h[F_VER_LSB  +: 3] = v;
        h[F_RST_BIT]       = r;
        return h;
    endfunction

endpackage

// File: rtl/mbx_poll_timer.sv
// Module: mbx_poll_timer
// Counts failed poll attempts in one phase and times the idle gap after each
// miss. Assumes arm_i and miss_i never coincide and POLL_GAP >= 1.
module mbx_poll_timer #(
    parameter int POLL_LIMIT = 20000,
    parameter int POLL_GAP   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic miss_i,
    input  logic in_gap_i,
    output logic last_o,
    output logic gap_over_o
);
    localparam int ATT_W = $clog2(POLL_LIMIT + 1);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(POLL_LIMIT - 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(POLL_GAP - 1);

    logic [ATT_W-1:0] att_q;
    logic [GAP_W-1:0] gap_q;

    // Attempt counter: cleared at phase start, bumped on each missed poll.
    always_ff @(posedge clk) begin
        if (!rst_n || arm_i)
            att_q <= '0;
        else if (miss_i)
            att_q <= att_q + 1'b1;
    end

    // Gap counter: loaded on a miss, counts down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (miss_i)
            gap_q <= GAP_LOAD;
        else if (in_gap_i && gap_q != '0)
            gap_q <= gap_q - 1'b1;
    end

    assign last_o     = (att_q == ATT_LAST);
    assign gap_over_o = (gap_q == '0);

    assert_attempt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        att_q < ATT_W'(POLL_LIMIT));

endmodule

// File: rtl/mbx_resp_check.sv
// Module: mbx_resp_check
// Classifies the control word read back from the window: ownership before
// the message, ownership after it, and the final verdict. Purely combinational.
module mbx_resp_check
    import mbx_seq_pkg::*;
(
    input  logic [HDR_W-1:0] rdata_i,
    input  logic [2:0]       type_i,
    input  logic [2:0]       ver_i,
    input  logic             rst_req_i,
    output logic             own_pre_o,
    output logic             own_post_o,
    output res_e             verdict_o
);
    logic all_ones;

    // Ownership decisions for the two polling phases.
    always_comb begin
        all_ones   = &rdata_i;
        own_pre_o  = !rdata_i[F_OWN_BIT];
        own_post_o = !rdata_i[F_OWN_BIT] || (rst_req_i && all_ones);
    end

    // Response verdict: reset shortcut, then protocol fields, then status.
    always_comb begin
        if (rst_req_i && all_ones)
            verdict_o = RES_OK;
        else if (rdata_i[F_TYPE_LSB +: 3] != type_i ||
                 rdata_i[F_VER_LSB +: 3] > ver_i ||
                 !rdata_i[F_DIR_BIT])
            verdict_o = RES_PROTO;
        else if (rdata_i[F_STAT_LSB +: 8] != 8'h00)
            verdict_o = RES_OPFAIL;
        else
            verdict_o = RES_OK;
    end

endmodule

// File: rtl/mbx_word_sel.sv
// Module: mbx_word_sel
// Picks the word to write at a given window index: a payload word below the
// last index, the header at the last index.
module mbx_word_sel
    import mbx_seq_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 3
) (
    input  logic [(NUM_WORDS-1)*HDR_W-1:0] payload_i,
    input  logic [HDR_W-1:0]               hdr_i,
    input  logic [ADDR_W-1:0]              idx_i,
    output logic [HDR_W-1:0]               word_o
);
    logic [HDR_W-1:0] words [NUM_WORDS];

    for (genvar k = 0; k < NUM_WORDS - 1; k++) begin : g_pay
        assign words[k] = payload_i[k*HDR_W +: HDR_W];
    end
    assign words[NUM_WORDS-1] = hdr_i;

    // Index the window image, zero for out-of-range indices.
    always_comb begin
        if (int'(idx_i) < NUM_WORDS)
            word_o = words[idx_i];
        else
            word_o = '0;
    end

endmodule

// File: rtl/mbx_req_seq.sv
// Module: mbx_req_seq (top)
// Runs one mailbox exchange per start command: poll for ownership, write the
// message (header last), poll for the hand-back and classify the answer.
// Assumes the bus slave eventually acknowledges every request and that
// NUM_WORDS >= 2. Command inputs are latched at start.
module mbx_req_seq
    import mbx_seq_pkg::*;
#(
    parameter int NUM_WORDS  = 8,
    parameter int POLL_LIMIT = 20000,
    parameter int POLL_GAP   = 1000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [2:0]                     msg_type_i,
    input  logic [2:0]                     msg_ver_i,
    input  logic                           reset_req_i,
    input  logic [(NUM_WORDS-1)*HDR_W-1:0] payload_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic [1:0]                     result_o,
    output logic                           bus_req_o,
    output logic                           bus_we_o,
    output logic [$clog2(NUM_WORDS)-1:0]   bus_addr_o,
    output logic [HDR_W-1:0]               bus_wdata_o,
    input  logic                           bus_ack_i,
    input  logic [HDR_W-1:0]               bus_rdata_i
);
    localparam int ADDR_W  = $clog2(NUM_WORDS);
    localparam int PAY_W   = (NUM_WORDS - 1) * HDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_WORDS - 1);

    st_e               state_q;
    logic [ADDR_W-1:0] idx_q;
    logic [2:0]        type_q, ver_q;
    logic              rst_q;
    logic [PAY_W-1:0]  pay_q;
    res_e              res_q;

    logic       own_pre, own_post, last, gap_over;
    logic       rd_state, in_gap, miss, arm, owned;
    res_e       verdict;
    logic [HDR_W-1:0] hdr_w;

    assign hdr_w = mk_header(type_q, ver_q, rst_q);

    mbx_resp_check u_chk (
        .rdata_i    (bus_rdata_i),
        .type_i     (type_q),
        .ver_i      (ver_q),
        .rst_req_i  (rst_q),
        .own_pre_o  (own_pre),
        .own_post_o (own_post),
        .verdict_o  (verdict)
    );

    mbx_word_sel #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_sel (
        .payload_i (pay_q),
        .hdr_i     (hdr_w),
        .idx_i     (idx_q),
        .word_o    (bus_wdata_o)
    );

    mbx_poll_timer #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm),
        .miss_i     (miss),
        .in_gap_i   (in_gap),
        .last_o     (last),
        .gap_over_o (gap_over)
    );

    // Phase decode and timer controls.
    always_comb begin
        rd_state = (state_q == ST_PRE_RD) || (state_q == ST_POST_RD);
        in_gap   = (state_q == ST_PRE_GAP) || (state_q == ST_POST_GAP);
        owned    = (state_q == ST_PRE_RD) ? own_pre : own_post;
        miss     = rd_state && bus_ack_i && !owned && !last;
        arm      = (start_i && state_q == ST_IDLE) ||
                   (state_q == ST_WRITE && bus_ack_i && idx_q == LAST);
    end

    // Bus and status outputs derived from the state.
    always_comb begin
        bus_req_o  = rd_state || (state_q == ST_WRITE);
        bus_we_o   = (state_q == ST_WRITE);
        bus_addr_o = (state_q == ST_WRITE) ? idx_q : LAST;
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE);
        result_o   = res_q;
    end

    // Sequencer state machine with command latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            type_q  <= '0;
            ver_q   <= '0;
            rst_q   <= 1'b0;
            pay_q   <= '0;
            res_q   <= RES_OK;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    type_q  <= msg_type_i;
                    ver_q   <= msg_ver_i;
                    rst_q   <= reset_req_i;
                    pay_q   <= payload_i;
                    state_q <= ST_PRE_RD;
                end
                ST_PRE_RD: if (bus_ack_i) begin
                    if (own_pre) begin
                        state_q <= ST_WRITE;
                        idx_q   <= (type_q == TYPE_SHORT) ? LAST : '0;
                    end else if (last) begin
                        res_q   <= RES_TIMEOUT;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_PRE_GAP;
                    end
                end
                ST_PRE_GAP: if (gap_over) state_q <= ST_PRE_RD;
                ST_WRITE: if (bus_ack_i) begin
                    if (idx_q == LAST) state_q <= ST_POST_RD;
                    else               idx_q   <= idx_q + 1'b1;
                end
                ST_POST_RD: if (bus_ack_i) begin
                    if (own_post) begin
                        res_q   <= verdict;
                        state_q <= ST_DONE;
                    end else if (last) begin
                        res_q   <= RES_TIMEOUT;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_POST_GAP;
                    end
                end
                ST_POST_GAP: if (gap_over) state_q <= ST_POST_RD;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) &&
        $stable(bus_addr_o) && $stable(bus_wdata_o));

    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o && !done_o);

    assert_write_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_we_o && bus_ack_i && bus_addr_o != LAST |=>
        bus_req_o && bus_we_o && bus_addr_o == ADDR_W'($past(bus_addr_o) + 1'b1));

    assert_hdr_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_we_o && bus_addr_o == LAST |->
        !bus_wdata_o[F_DIR_BIT] && bus_wdata_o[F_STAT_LSB +: 8] == 8'h00 &&
        !bus_wdata_o[F_OWN_BIT]);

    assert_short_hdr_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_we_o && type_q == TYPE_SHORT |-> bus_addr_o == LAST);

endmodule

// File: tb/mbx_req_seq_tb.sv
module mbx_req_seq_tb_top;
    import mbx_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LIM = 5;
    localparam int GAP = 3;
    localparam int LAT = 2;
    localparam int PW  = 7;
    localparam logic [31:0] BUSYW = 32'h8000_0000;
    localparam logic [31:0] ONES  = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] mtype = '0, mver = '0;
    logic rreq = 1'b0;
    logic [PW*32-1:0] payload = '0;
    logic busy, done, req, we;
    logic [1:0] result;
    logic [2:0] addr;
    logic [31:0] wdata;
    logic ack = 1'b0;
    logic [31:0] rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_req_seq #(.NUM_WORDS(8), .POLL_LIMIT(LIM), .POLL_GAP(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .msg_type_i(mtype),
        .msg_ver_i(mver), .reset_req_i(rreq), .payload_i(payload),
        .busy_o(busy), .done_o(done), .result_o(result),
        .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr),
        .bus_wdata_o(wdata), .bus_ack_i(ack), .bus_rdata_i(rdata)
    );

    typedef struct packed { logic w; logic [2:0] a; logic [31:0] d; } xact_t;
    xact_t exp_q[$];
    logic [31:0] resp_src[$];
    logic [31:0] resp_live[$];
    int checks = 0, errors = 0;
    int accepted = 0, dones = 0, lat_cnt = 0, idle_run = 0, case_no = 0;
    logic exp_busy = 1'b0;
    string cur_tag = "R1";

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rsp(input logic [2:0] t, input logic [2:0] v,
                                        input logic dir, input logic [7:0] st);
        return {1'b0, 6'b0, 1'b0, 8'h00, st, dir, 1'b0, v, t};
    endfunction

    // Reference model: expected accesses and result, from the requirements.
    task automatic plan(input logic [2:0] t, input logic [2:0] v, input logic r,
                        input logic [PW*32-1:0] pay, output logic [1:0] res);
        int k;
        bit owned;
        logic [31:0] val;
        logic [31:0] hdr;
        k = 0;
        val = '0;
        hdr = {1'b0, 6'b0, r, 8'h00, 8'h00, 1'b0, 1'b0, v, t};
        owned = 0;
        for (int i = 0; i < LIM && !owned; i++) begin
            val = (k < resp_src.size()) ? resp_src[k] : 32'h0;
            k++;
            exp_q.push_back('{1'b0, 3'd7, 32'h0});
            owned = !val[31];
        end
        if (!owned) begin res = 2'd1; return; end
        if (t != 3'd2)
            for (int w = 0; w < PW; w++) exp_q.push_back('{1'b1, 3'(w), pay[w*32 +: 32]});
        exp_q.push_back('{1'b1, 3'd7, hdr});
        owned = 0;
        for (int i = 0; i < LIM && !owned; i++) begin
            val = (k < resp_src.size()) ? resp_src[k] : 32'h0;
            k++;
            exp_q.push_back('{1'b0, 3'd7, 32'h0});
            owned = !val[31] || (r && val == ONES);
        end
        if (!owned)                                        res = 2'd1;
        else if (r && val == ONES)                         res = 2'd0;
        else if (val[2:0] != t || val[5:3] > v || !val[7]) res = 2'd2;
        else if (val[15:8] != 8'h00)                       res = 2'd3;
        else                                               res = 2'd0;
    endtask

    // Busy model updated on the same edge the design sees.
    always @(posedge clk) begin
        if (!rst_n) exp_busy <= 1'b0;
        else if (start && !busy) begin exp_busy <= 1'b1; accepted <= accepted + 1; end
        else if (done) exp_busy <= 1'b0;
    end

    // Per-clock compare, gap timing and bus slave, all away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == exp_busy, "R1", "busy vs model", busy, exp_busy);
            if (done) begin dones++; idle_run = 0; end
            else if (busy && !req) idle_run++;
            if (req && idle_run > 0) begin
                check(idle_run == GAP, "R3", "idle cycles between polls", idle_run, GAP);
                idle_run = 0;
            end
        end
        if (ack) begin
            ack = 1'b0;
            lat_cnt = 0;
        end else if (req) begin
            lat_cnt++;
            if (lat_cnt >= LAT) begin
                ack = 1'b1;
                if (exp_q.size() == 0) begin
                    check(0, cur_tag, "unexpected bus access", {we, addr, wdata}, 0);
                end else begin
                    xact_t e;
                    e = exp_q.pop_front();
                    check(we == e.w && addr == e.a && (!we || wdata == e.d), cur_tag,
                          "bus access (R2 R4 R6 R10)", {we, addr, wdata}, e);
                end
                if (!we) rdata = (resp_live.size() > 0) ? resp_live.pop_front() : 32'h0;
            end
        end
    end

    task automatic run_case(input string tag, input logic [2:0] t, input logic [2:0] v,
                            input logic r, input bit poke);
        logic [1:0] er;
        int d0, w;
        cur_tag = tag;
        case_no++;
        for (int k = 0; k < PW; k++) payload[k*32 +: 32] = 32'hA500_0000 + case_no * 256 + k;
        exp_q.delete();
        plan(t, v, r, payload, er);
        resp_live = resp_src;
        d0 = dones;
        @(negedge clk);
        mtype = t; mver = v; rreq = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            mtype = 3'd5; rreq = ~r; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 3000) begin @(negedge clk); w++; end
        check(done == 1'b1, tag, "done reached", done, 1);
        check(result == er, tag, "result code", result, er);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, tag, "all expected accesses seen", exp_q.size(), 0);
        check(dones == d0 + 1, tag, "one done per command", dones - d0, 1);
        check(accepted == dones, "R1", "accepted vs done count", accepted, dones);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !req, "R1", "reset state", {busy, done, req}, 0);

        resp_src = '{BUSYW, BUSYW, 32'h0, BUSYW, rsp(3'd1, 3'd0, 1'b1, 8'h00)};
        run_case("R2", 3'd1, 3'd0, 1'b0, 0);
        resp_src = '{32'h0, rsp(3'd2, 3'd1, 1'b1, 8'h00)};
        run_case("R5", 3'd2, 3'd1, 1'b0, 0);
        resp_src = '{32'h0, ONES};
        run_case("R7", 3'd2, 3'd0, 1'b1, 0);
        resp_src = '{ONES, 32'h0, BUSYW, rsp(3'd1, 3'd0, 1'b1, 8'h00)};
        run_case("R7", 3'd1, 3'd0, 1'b1, 0);
        resp_src = '{32'h0, rsp(3'd1, 3'd1, 1'b1, 8'h00)};
        run_case("R8", 3'd1, 3'd2, 1'b0, 0);
        resp_src = '{32'h0, rsp(3'd1, 3'd3, 1'b1, 8'h00)};
        run_case("R8", 3'd1, 3'd2, 1'b0, 0);
        resp_src = '{32'h0, rsp(3'd2, 3'd0, 1'b1, 8'h00)};
        run_case("R8", 3'd1, 3'd0, 1'b0, 0);
        resp_src = '{32'h0, rsp(3'd1, 3'd0, 1'b0, 8'h00)};
        run_case("R8", 3'd1, 3'd0, 1'b0, 0);
        resp_src = '{32'h0, rsp(3'd1, 3'd0, 1'b1, 8'h05)};
        run_case("R9", 3'd1, 3'd0, 1'b0, 0);
        resp_src = '{32'h0, rsp(3'd3, 3'd0, 1'b1, 8'h07)};
        run_case("R9", 3'd1, 3'd0, 1'b0, 0);
        resp_src = '{BUSYW, BUSYW, BUSYW, BUSYW, BUSYW, 32'h0};
        run_case("R3", 3'd1, 3'd0, 1'b0, 0);
        resp_src = '{32'h0, ONES, ONES, ONES, ONES, ONES};
        run_case("R3", 3'd1, 3'd0, 1'b0, 0);
        resp_src = '{BUSYW, 32'h0, BUSYW, BUSYW, rsp(3'd1, 3'd0, 1'b1, 8'h00)};
        run_case("R1", 3'd1, 3'd0, 1'b0, 1);
        resp_src = '{32'h0, rsp(3'd1, 3'd3, 1'b1, 8'h00)};
        run_case("R6", 3'd1, 3'd3, 1'b1, 0);
        resp_src = '{BUSYW, 32'h0, BUSYW, BUSYW, rsp(3'd4, 3'd0, 1'b1, 8'h00)};
        run_case("R10", 3'd4, 3'd0, 1'b0, 0);
        resp_src = '{32'h0, rsp(3'd6, 3'd0, 1'b1, 8'h00)};
        run_case("R4", 3'd6, 3'd0, 1'b0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule